// File: doc/BRIEF.md
# Priority-Threshold Interrupt Router

This block gathers 56 level-sensitive interrupt request lines and routes each one to one of two processor request outputs: a fast request and a standard request. Every source carries its own configuration word holding a 4-bit priority, a polarity flag, a destination flag and a software request bit. Each destination has its own priority threshold. A source takes part in arbitration for its destination only when its priority is strictly above that destination's threshold. Priority 0 is therefore always masked.

For each destination the block registers a request output and the index of the winning source. The winner is the pending, unmasked source with the highest priority. When priorities tie, the lowest index wins. Nested service works through the thresholds alone: a handler raises its destination's threshold to the priority it is serving and restores the old value on exit.

A simple synchronous register bus writes the configuration and thresholds. Over the same bus, software reads back the raw request levels, the masked status and a vector word for each destination.

Top module: `prio_irq_router`

## Requirements
- R1: Each source is active when its line is high while its polarity flag (config bit 5) is 0, and when its line is low while that flag is 1.
- R2: Setting a source's software request bit (config bit 6) makes that source pending regardless of its line.
- R3: A source with priority 0 (config bits 3:0) never asserts either request output and never appears in a vector.
- R4: Destination bit (config bit 4) value 0 sends a source to the fast output; value 1 sends it to the standard output; a source never affects the other destination.
- R5: A source qualifies for its destination only if its priority is strictly greater than that destination's threshold (fast threshold at address 0x40, standard at 0x41, bits 3:0).
- R6: Each destination's request output is high exactly when at least one source qualifies, and its source output names the qualifying source of highest priority.
- R7: Among qualifying sources of equal top priority, the lowest index is reported.
- R8: Raw status words (0x42 for sources 0..31, 0x43 bits 23:0 for sources 32..55) give each source's pending state after polarity and software request, before any masking.
- R9: The vector words (0x44 fast, 0x45 standard) hold the source index in bits 7:0, its priority in bits 11:8 and a valid flag in bit 31, and the whole word reads zero when nothing qualifies.
- R10: A change on a request line appears on the request and source outputs after exactly one rising clock edge.
- R11: Masked status words (0x46 for sources 0..31, 0x47 for sources 32..55) show which sources currently qualify for their own destination.
- R12: Raising a destination's threshold to the priority being serviced blocks further requests at that priority while still letting higher ones through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 56 | Request lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Register address; 0x00..0x37 select source configuration words |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one edge after the read strobe |
| fast_req | output | 1 | Fast interrupt request |
| fast_src | output | 6 | Winning source index for the fast request |
| std_req | output | 1 | Standard interrupt request |
| std_src | output | 6 | Winning source index for the standard request |

## Verification
The assertions check four properties on every cycle:
- the reported winner was eligible one cycle earlier;
- its priority is non-zero;
- its priority exceeded the threshold in force one cycle earlier;
- the vector is all zero whenever the request is low.

Only the bench scenarios can show the rest: polarity inversion, software-forced requests, routing to the correct destination, the lowest-index tie-break, the exact one-edge latency, and the nested-threshold sequence. For each of these the bench compares the output pins and register reads against a model built from the requirements.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PRIO_W = 4;

  typedef struct packed {
    logic              swreq;
    logic              inv;
    logic              dest;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);

  // Whether a pending source competes for destination dest_id.
  function automatic logic qualifies(input logic pend, input logic dest,
                                     input logic dest_id,
                                     input logic [PRIO_W-1:0] prio,
                                     input logic [PRIO_W-1:0] thr);
    return pend && (dest == dest_id) && (prio > thr);
  endfunction

  // Vector word: bit 31 valid, 11:8 priority, 7:0 index.
  function automatic logic [31:0] pack_vec(input logic valid,
                                           input logic [PRIO_W-1:0] prio,
                                           input logic [7:0] idx);
    return {valid, 19'd0, prio, idx};
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 56,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_line,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  src_cfg_t           wr_cfg,
  output src_cfg_t           cfg_q [NUM_SRC],
  output logic [NUM_SRC-1:0] raw_pend
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);

    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[i] <= '0;
      else if (wr_en && (wr_idx == MY_IDX))
        cfg_q[i] <= wr_cfg;
    end

    // Polarity-corrected level, ORed with the software request.
    assign raw_pend[i] = (irq_line[i] ^ cfg_q[i].inv) | cfg_q[i].swreq;
  end
endmodule

// File: rtl/irq_dest_arb.sv
module irq_dest_arb
  import prio_irq_pkg::*;
#(
  parameter int   NUM_SRC = 56,
  parameter logic DEST_ID = 1'b0,
  localparam int  IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raw_pend,
  input  src_cfg_t           cfg [NUM_SRC],
  input  logic [PRIO_W-1:0]  thr,
  output logic [NUM_SRC-1:0] elig,
  output logic               req_q,
  output logic [IDX_W-1:0]   src_q,
  output logic [PRIO_W-1:0]  prio_q
);
  logic               best_v;
  logic [PRIO_W-1:0]  best_p;
  logic [IDX_W-1:0]   best_i;
  logic [NUM_SRC-1:0] elig_q;

  // Strict '>' keeps the first (lowest) index on a priority tie.
  always_comb begin
    best_v = 1'b0;
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      elig[i] = qualifies(raw_pend[i], cfg[i].dest, DEST_ID, cfg[i].prio, thr);
      if (elig[i] && (cfg[i].prio > best_p)) begin
        best_v = 1'b1;
        best_p = cfg[i].prio;
        best_i = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      src_q  <= '0;
      prio_q <= '0;
      elig_q <= '0;
    end else begin
      req_q  <= best_v;
      src_q  <= best_i;
      prio_q <= best_p;
      elig_q <= elig;
    end
  end

  // R6: the reported winner was eligible when it was chosen.
  a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> elig_q[src_q]);

  // R3: a priority-0 source never wins.
  a_r3_prio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (prio_q != '0));

  // R5: the winner was strictly above the threshold one cycle earlier.
  a_r5_above_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (prio_q > $past(thr)));

  // R9: with no request, the vector is zero.
  a_r9_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> (src_q == '0 && prio_q == '0));
endmodule

// File: rtl/prio_irq_router.sv
module prio_irq_router
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 56,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_line,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               fast_req,
  output logic [IDX_W-1:0]   fast_src,
  output logic               std_req,
  output logic [IDX_W-1:0]   std_src
);
  localparam int NUM_DEST = 2;
  localparam int STAT_W   = 64;
  localparam logic [ADDR_W-1:0] A_THR    = ADDR_W'(7'h40);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(7'h42);
  localparam logic [ADDR_W-1:0] A_VEC    = ADDR_W'(7'h44);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(7'h46);

  src_cfg_t           cfg_q [NUM_SRC];
  logic [NUM_SRC-1:0] raw_pend;
  logic [PRIO_W-1:0]  thr_q [NUM_DEST];
  logic [NUM_SRC-1:0] elig     [NUM_DEST];
  logic               d_req    [NUM_DEST];
  logic [IDX_W-1:0]   d_src    [NUM_DEST];
  logic [PRIO_W-1:0]  d_prio   [NUM_DEST];

  logic wr_cycle, rd_cycle, cfg_wr;
  assign wr_cycle = bus_sel &&  bus_wr;
  assign rd_cycle = bus_sel && !bus_wr;
  assign cfg_wr   = wr_cycle && (32'(bus_addr) < NUM_SRC);

  irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_line (irq_line),
    .wr_en    (cfg_wr),
    .wr_idx   (bus_addr[IDX_W-1:0]),
    .wr_cfg   (src_cfg_t'(bus_wdata[CFG_W-1:0])),
    .cfg_q    (cfg_q),
    .raw_pend (raw_pend)
  );

  for (genvar t = 0; t < NUM_DEST; t++) begin : g_dest
    always_ff @(posedge clk) begin
      if (!rst_n)
        thr_q[t] <= '0;
      else if (wr_cycle && (bus_addr == A_THR + ADDR_W'(t)))
        thr_q[t] <= bus_wdata[PRIO_W-1:0];
    end

    irq_dest_arb #(.NUM_SRC(NUM_SRC), .DEST_ID(t[0])) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_pend (raw_pend),
      .cfg      (cfg_q),
      .thr      (thr_q[t]),
      .elig     (elig[t]),
      .req_q    (d_req[t]),
      .src_q    (d_src[t]),
      .prio_q   (d_prio[t])
    );
  end

  assign fast_req = d_req[0];
  assign fast_src = d_src[0];
  assign std_req  = d_req[1];
  assign std_src  = d_src[1];

  logic [STAT_W-1:0] raw_pad, masked_pad;
  assign raw_pad    = STAT_W'(raw_pend);
  assign masked_pad = STAT_W'(elig[0] | elig[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_cycle) begin
      if (32'(bus_addr) < NUM_SRC)
        bus_rdata <= DATA_W'(cfg_q[bus_addr[IDX_W-1:0]]);
      else begin
        case (bus_addr)
          A_THR:          bus_rdata <= DATA_W'(thr_q[0]);
          A_THR + 7'd1:   bus_rdata <= DATA_W'(thr_q[1]);
          A_RAW:          bus_rdata <= raw_pad[31:0];
          A_RAW + 7'd1:   bus_rdata <= raw_pad[63:32];
          A_VEC:          bus_rdata <= pack_vec(d_req[0], d_prio[0], 8'(d_src[0]));
          A_VEC + 7'd1:   bus_rdata <= pack_vec(d_req[1], d_prio[1], 8'(d_src[1]));
          A_MASKED:       bus_rdata <= masked_pad[31:0];
          A_MASKED + 7'd1: bus_rdata <= masked_pad[63:32];
          default:        bus_rdata <= '0;
        endcase
      end
    end
  end

  // R4: a source routed to one destination is never eligible for the other.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_route_chk
    a_r4_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
      !(elig[0][s] && elig[1][s]));
  end
endmodule

// File: tb/prio_irq_router_bench.sv
`timescale 1ns/1ps
module prio_irq_router_bench;
  localparam int N = 56;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_line = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fast_req, std_req;
  logic [5:0]  fast_src, std_src;

  always #4 clk = ~clk;

  prio_irq_router u_prio_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fast_req(fast_req), .fast_src(fast_src),
    .std_req(std_req), .std_src(std_src)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [3:0] m_prio [N];
  bit         m_dest [N];
  bit         m_inv  [N];
  bit         m_sw   [N];
  logic [3:0] m_thr  [2];

  function automatic bit m_pend(int i);
    return (irq_line[i] ^ m_inv[i]) | m_sw[i];
  endfunction

  function automatic bit m_qual(int i);
    return m_pend(i) && (m_prio[i] > m_thr[m_dest[i]]);
  endfunction

  // Expected vector word for destination t.
  function automatic logic [31:0] exp_vec(int t);
    logic [3:0] bp = 0; int bi = 0; bit bv = 0;
    for (int i = 0; i < N; i++)
      if (m_qual(i) && m_dest[i] == t[0] && m_prio[i] > bp) begin
        bp = m_prio[i]; bi = i; bv = 1;
      end
    return bv ? {1'b1, 19'd0, bp, 8'(bi)} : 32'd0;
  endfunction

  function automatic logic [63:0] exp_raw();
    logic [63:0] r = 0;
    for (int i = 0; i < N; i++) r[i] = m_pend(i);
    return r;
  endfunction

  function automatic logic [63:0] exp_masked();
    logic [63:0] r = 0;
    for (int i = 0; i < N; i++) r[i] = m_qual(i);
    return r;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic cfg_src(int i, logic [3:0] p, bit dst, bit inv, bit sw);
    m_prio[i] = p; m_dest[i] = dst; m_inv[i] = inv; m_sw[i] = sw;
    bus_write(7'(i), {25'd0, sw, inv, dst, p});
  endtask

  task automatic set_thr(int t, logic [3:0] v);
    m_thr[t] = v;
    bus_write(7'h40 + 7'(t), {28'd0, v});
  endtask

  // Compare pins and vector registers for both destinations.
  task automatic check_all(string tag);
    logic [31:0] ef, es, rd;
    @(negedge clk);
    ef = exp_vec(0); es = exp_vec(1);
    check(tag, "fast_req", fast_req, ef[31]);
    check(tag, "fast_src", fast_src, ef[5:0]);
    check(tag, "std_req", std_req, es[31]);
    check(tag, "std_src", std_src, es[5:0]);
    bus_read(7'h44, rd); check(tag, "fast vector", rd, ef);
    bus_read(7'h45, rd); check(tag, "std vector", rd, es);
  endtask

  task automatic check_status(string tag);
    logic [31:0] lo, hi; logic [63:0] e;
    e = exp_raw();
    bus_read(7'h42, lo); bus_read(7'h43, hi);
    check(tag, "raw status", {hi, lo}, e);
    e = exp_masked();
    bus_read(7'h46, lo); bus_read(7'h47, hi);
    check(tag, "masked status", {hi, lo}, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_prio[i] = 0; m_dest[i] = 0; m_inv[i] = 0; m_sw[i] = 0;
    end
    m_thr[0] = 0; m_thr[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // Reset state: no requests, zero vectors (R9).
    check_all("R9");
    check_status("R8");

    // R10: single-edge latency on the fast output.
    cfg_src(5, 4'd3, 0, 0, 0);
    @(negedge clk); irq_line[5] = 1;
    #1 check("R10", "fast_req before edge", fast_req, 1'b0);
    @(negedge clk);
    check("R10", "fast_req after one edge", fast_req, 1'b1);
    check("R10", "fast_src after one edge", fast_src, 6'd5);
    check_all("R6");

    // R5: threshold equal blocks, one less passes.
    set_thr(0, 4'd3); check_all("R5");
    set_thr(0, 4'd2); check_all("R5");

    // R3: priority 0 is masked even with threshold 0.
    set_thr(0, 4'd0);
    cfg_src(5, 4'd0, 0, 0, 0); check_all("R3");
    check_status("R11");

    // R1: active-low source asserted while its line is low.
    cfg_src(9, 4'd6, 1, 1, 0); check_all("R1");
    irq_line[9] = 1; check_all("R1");
    check_status("R8");

    // R2: software request with line inactive.
    cfg_src(40, 4'd2, 1, 0, 1); check_all("R2");
    check_status("R8");
    cfg_src(40, 4'd0, 1, 0, 0);

    // R4: routing; moving a source to the other destination.
    cfg_src(12, 4'd7, 1, 0, 0); irq_line[12] = 1; check_all("R4");
    cfg_src(12, 4'd7, 0, 0, 0); check_all("R4");

    // R7: tie at top priority, lowest index wins.
    cfg_src(30, 4'd9, 0, 0, 0); cfg_src(20, 4'd9, 0, 0, 0);
    irq_line[30] = 1; irq_line[20] = 1;
    check_all("R7");
    check("R7", "fast_src tie", fast_src, 6'd20);

    // R12: nested service at priority 9; equal blocked, higher passes.
    set_thr(0, 4'd9); check_all("R12");
    check("R12", "fast_req masked at serviced level", fast_req, 1'b0);
    cfg_src(50, 4'd11, 0, 0, 1); check_all("R12");
    check("R12", "higher preempts", fast_src, 6'd50);
    set_thr(0, 4'd0); cfg_src(50, 4'd0, 0, 0, 0); check_all("R12");
    check_status("R11");

    // Random mix across all requirements (R6, R8, R11).
    for (int it = 0; it < 150; it++) begin
      for (int k = 0; k < 3; k++)
        cfg_src($urandom_range(N-1), 4'($urandom), 1'($urandom),
                1'($urandom), ($urandom_range(7) == 0));
      if ($urandom_range(3) == 0) set_thr($urandom_range(1), 4'($urandom_range(12)));
      @(negedge clk); irq_line = N'({$urandom, $urandom});
      check_all("R6");
      if (it % 10 == 0) check_status("R11");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule